// File: doc/BRIEF.md
# Interlocked Clock Source Switch Controller

This block picks the main clock from one of two free-running, mutually asynchronous sources: an on-chip high-speed oscillator and an external high-speed clock. The hand-over between them is glitch-free. The old source's enable is dropped on that source's falling edge. The new source's enable rises on its own falling edge, and only once a two-flop synchronizer in the new domain has seen the old enable low. Neither source ever drives the output at the same time as the other.

Software uses a small register on a bus clock. One write carries five fields: the source request, a one-shot arming bit that must be set before the external clock may be chosen, and three stop requests (on-chip oscillator, external clock, subsystem oscillator). Each stop request is refused while the CPU could still depend on that source. A status output reports which source really drives the output, and software polls it rather than its own request. A request made while a switch is under way is held, and is applied once that switch completes. The `sub_sel` input tells the block whether the CPU currently runs from the subsystem clock.

Top module: `clk_src_switch`

## Requirements
- R1: After reset `on_ext` is 0, `ctl_q` is 0 and `clk_main` follows `clk_int`.
- R2: `ctl_q` reads back the register one bus-clock edge after a write with `wr_en` high. Bit 0 is the source request (0 on-chip, 1 external), bit 1 is the arming bit, bit 2 is the on-chip stop, bit 3 is the external stop and bit 4 is the subsystem stop. All five fields are written together, subject to R3, R4, R9, R10 and R11.
- R3: The arming bit becomes 1 on the first write with bit 1 set, and no later write can return it to 0 before reset.
- R4: A request for the external source (bit 0 = 1) takes effect only if the arming bit was already 1 before that write. Otherwise bit 0 keeps its value and the output stays on the on-chip source. A request for the on-chip source is always taken.
- R5: `on_ext` changes only after the output enable of the new source is up and the old one is down. With both sources no slower than three bus-clock periods, `on_ext` reaches the requested value within 40 bus-clock cycles of the write.
- R6: Once `on_ext` has settled, `clk_main` has the period of the source it names.
- R7: Every high or low phase of `clk_main` lasts at least half a period of the faster source. During a switch no phase lasts longer than three periods of the new source.
- R8: A request that arrives while a switch is under way is held. Once the running switch completes, the output moves to the latest requested source.
- R9: Setting the on-chip stop is taken only while `on_ext` is 1 or `sub_sel` is 1. Clearing it is always taken.
- R10: Setting the external stop is taken only while `on_ext` is 0 or `sub_sel` is 1. Clearing it is always taken.
- R11: Setting the subsystem stop is taken only while `sub_sel` is 0. Clearing it is always taken.
- R12: The two source enables are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Bus clock for the register and status |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_int | input | 1 | On-chip high-speed oscillator |
| clk_ext | input | 1 | External high-speed clock |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 5 | Register write value (fields as in R2) |
| sub_sel | input | 1 | CPU runs from the subsystem clock |
| clk_main | output | 1 | Gated main clock |
| on_ext | output | 1 | Status: 1 when the external clock drives `clk_main` |
| ctl_q | output | 5 | Register read-back |

## Verification
The assertions take for granted that `wr_en`, `wr_data` and `sub_sel` are synchronous to `cfg_clk` and that both source clocks keep toggling, even after a stop bit is set, because the stop bits only report permission. The bench changes every input on the falling edge of `cfg_clk` and keeps both sources running throughout. The only time it changes the source request while a switch is in progress is the held-request case.

// File: rtl/clk_src_switch.sv
module clk_src_switch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       cfg_clk,
  input  logic       rst_n,
  input  logic       clk_int,
  input  logic       clk_ext,
  input  logic       wr_en,
  input  logic [4:0] wr_data,
  input  logic       sub_sel,
  output logic       clk_main,
  output logic       on_ext,
  output logic [4:0] ctl_q
);
  localparam int LAST = SYNC_STAGES - 1;

  logic sel, arm, stop_int, stop_ext, stop_sub;
  logic want;
  logic en_int, en_ext;
  logic [LAST:0] want_si, oth_si, want_se, oth_se, en_int_c, en_ext_c;

  logic sel_ok, si_ok, se_ok, ss_ok;
  assign sel_ok = !wr_data[0] || arm;
  assign si_ok  = !wr_data[2] || on_ext || sub_sel;
  assign se_ok  = !wr_data[3] || !on_ext || sub_sel;
  assign ss_ok  = !wr_data[4] || !sub_sel;

  always_ff @(posedge cfg_clk or negedge rst_n)
    if (!rst_n) begin
      sel <= 1'b0; arm <= 1'b0;
      stop_int <= 1'b0; stop_ext <= 1'b0; stop_sub <= 1'b0;
    end else if (wr_en) begin
      if (sel_ok)     sel      <= wr_data[0];
      if (wr_data[1]) arm      <= 1'b1;
      if (si_ok)      stop_int <= wr_data[2];
      if (se_ok)      stop_ext <= wr_data[3];
      if (ss_ok)      stop_sub <= wr_data[4];
    end

  always_ff @(posedge cfg_clk or negedge rst_n)
    if (!rst_n) begin
      want     <= 1'b0;
      on_ext   <= 1'b0;
      en_int_c <= '1;
      en_ext_c <= '0;
    end else begin
      en_int_c <= {en_int_c[LAST-1:0], en_int};
      en_ext_c <= {en_ext_c[LAST-1:0], en_ext};
      if (want == on_ext) want <= sel;
      if (en_ext_c[LAST] && !en_int_c[LAST])      on_ext <= 1'b1;
      else if (en_int_c[LAST] && !en_ext_c[LAST]) on_ext <= 1'b0;
    end

  always_ff @(posedge clk_int or negedge rst_n)
    if (!rst_n) begin
      want_si <= '0;
      oth_si  <= '0;
    end else begin
      want_si <= {want_si[LAST-1:0], want};
      oth_si  <= {oth_si[LAST-1:0], en_ext};
    end

  always_ff @(negedge clk_int or negedge rst_n)
    if (!rst_n) en_int <= 1'b1;
    else        en_int <= !want_si[LAST] && !oth_si[LAST];

  always_ff @(posedge clk_ext or negedge rst_n)
    if (!rst_n) begin
      want_se <= '0;
      oth_se  <= '1;
    end else begin
      want_se <= {want_se[LAST-1:0], want};
      oth_se  <= {oth_se[LAST-1:0], en_int};
    end

  always_ff @(negedge clk_ext or negedge rst_n)
    if (!rst_n) en_ext <= 1'b0;
    else        en_ext <= want_se[LAST] && !oth_se[LAST];

  assign clk_main = (clk_int && en_int) || (clk_ext && en_ext);
  assign ctl_q    = {stop_sub, stop_ext, stop_int, arm, sel};
endmodule

module clk_src_switch_chk (
  input logic       cfg_clk,
  input logic       rst_n,
  input logic [4:0] ctl_q,
  input logic       on_ext,
  input logic       sub_sel,
  input logic       want,
  input logic       en_int,
  input logic       en_ext
);
  // R3
  arm_sticky_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    !$fell(ctl_q[1]));
  // R4
  sel_armed_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    $rose(ctl_q[0]) |-> $past(ctl_q[1]));
  // R9
  int_stop_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    $rose(ctl_q[2]) |-> $past(on_ext || sub_sel));
  // R10
  ext_stop_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    $rose(ctl_q[3]) |-> $past(!on_ext || sub_sel));
  // R11
  sub_stop_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    $rose(ctl_q[4]) |-> $past(!sub_sel));
  // R5
  status_dir_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    !$stable(on_ext) |-> (on_ext == want));
  // R12
  excl_en_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    !(en_int && en_ext));
endmodule

bind clk_src_switch clk_src_switch_chk u_chk (
  .cfg_clk(cfg_clk), .rst_n(rst_n), .ctl_q(ctl_q), .on_ext(on_ext),
  .sub_sel(sub_sel), .want(want), .en_int(en_int), .en_ext(en_ext)
);

// File: tb/clk_src_switch_bench.sv
`timescale 1ns/1ps
module clk_src_switch_bench;
  logic cfg_clk = 0, clk_int = 0, clk_ext = 0, rst_n = 0;
  logic wr_en = 0, sub_sel = 0;
  logic [4:0] wr_data = '0;
  logic clk_main, on_ext;
  logic [4:0] ctl_q;

  int checks = 0, fails = 0;
  bit done = 0, meas = 0;
  real t_last = -1.0, min_ph = 1.0e9, max_ph = 0.0;

  always #2 cfg_clk = ~cfg_clk;
  always #5 clk_int = ~clk_int;
  always #4 clk_ext = ~clk_ext;

  clk_src_switch u_clk_src_switch (
    .cfg_clk(cfg_clk), .rst_n(rst_n), .clk_int(clk_int), .clk_ext(clk_ext),
    .wr_en(wr_en), .wr_data(wr_data), .sub_sel(sub_sel),
    .clk_main(clk_main), .on_ext(on_ext), .ctl_q(ctl_q)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference register model, stepped on every bus clock edge
  logic m_sel = 0, m_arm = 0, m_si = 0, m_se = 0, m_ss = 0;
  always @(posedge cfg_clk) begin
    if (!rst_n) begin
      m_sel = 0; m_arm = 0; m_si = 0; m_se = 0; m_ss = 0;
    end else if (wr_en) begin
      if (wr_data[0] == 0 || m_arm == 1) m_sel = wr_data[0];
      if (wr_data[2] == 0 || on_ext || sub_sel) m_si = wr_data[2];
      if (wr_data[3] == 0 || !on_ext || sub_sel) m_se = wr_data[3];
      if (wr_data[4] == 0 || !sub_sel) m_ss = wr_data[4];
      if (wr_data[1]) m_arm = 1;
    end
  end

  // R2 R3 R4 R9 R10 R11: register compared on every bus clock
  always @(negedge cfg_clk) if (rst_n && !done)
    check(ctl_q == {m_ss, m_se, m_si, m_arm, m_sel}, "R2_reg", ctl_q,
          int'({m_ss, m_se, m_si, m_arm, m_sel}));

  always @(clk_main) if (meas) begin
    if (t_last >= 0.0) begin
      if ($realtime - t_last < min_ph) min_ph = $realtime - t_last;
      if ($realtime - t_last > max_ph) max_ph = $realtime - t_last;
    end
    t_last = $realtime;
  end

  task automatic wr(input logic [4:0] d);
    @(negedge cfg_clk); wr_en = 1; wr_data = d;
    @(negedge cfg_clk); wr_en = 0;
  endtask

  task automatic wait_status(input logic exp, input string req);
    bit hit = 0;
    for (int i = 0; i < 40 && !hit; i++) begin
      @(negedge cfg_clk);
      if (on_ext == exp) hit = 1;
    end
    check(hit, req, on_ext, exp);
  endtask

  task automatic period(input real exp, input string req);
    real t0;
    repeat (4) @(posedge clk_main);
    t0 = $realtime;
    @(posedge clk_main);
    check(($realtime - t0) > exp - 0.1 && ($realtime - t0) < exp + 0.1, req,
          int'($realtime - t0), int'(exp));
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge cfg_clk);
    check(on_ext == 0 && ctl_q == 0, "R1_reset", ctl_q, 0);
    rst_n = 1;
    meas = 1;
    period(10.0, "R1_follows_int");
    // R4: external request without arming is ignored
    wr(5'b00001);
    repeat (40) @(negedge cfg_clk);
    check(on_ext == 0 && ctl_q[0] == 0, "R4_unarmed", on_ext, 0);
    // R10: external stop allowed on the on-chip source; R9 refused
    wr(5'b01000);
    check(ctl_q[3] == 1, "R10_set", ctl_q[3], 1);
    wr(5'b00100);
    check(ctl_q[2] == 0, "R9_refused", ctl_q[2], 0);
    wr(5'b00000);
    // R3: arm then try to clear
    wr(5'b00010);
    check(ctl_q[1] == 1, "R3_arm", ctl_q[1], 1);
    wr(5'b00000);
    check(ctl_q[1] == 1, "R3_sticky", ctl_q[1], 1);
    // R5 R6: go external
    wr(5'b00001);
    check(on_ext == 0, "R5_not_early", on_ext, 0);
    wait_status(1, "R5_to_ext");
    period(8.0, "R6_ext_period");
    wr(5'b00101);
    check(ctl_q[2] == 1, "R9_set", ctl_q[2], 1);
    wr(5'b01001);
    check(ctl_q[3] == 0, "R10_refused", ctl_q[3], 0);
    wr(5'b00001);
    // back to on-chip
    wr(5'b00000);
    wait_status(0, "R5_to_int");
    period(10.0, "R6_int_period");
    // R8: held request
    wr(5'b00001);
    wr(5'b00000);
    wait_status(1, "R8_first");
    wait_status(0, "R8_held");
    period(10.0, "R8_final_period");
    // R9 R11 with subsystem selected
    sub_sel = 1;
    wr(5'b10100);
    check(ctl_q[2] == 1 && ctl_q[4] == 0, "R11_refused", ctl_q, 5'b00100);
    sub_sel = 0;
    wr(5'b10000);
    check(ctl_q[4] == 1 && ctl_q[2] == 0, "R11_set", ctl_q, 5'b10000);
    // R7: phase limits over the whole run
    check(min_ph > 3.9, "R7_min_phase", int'(min_ph), 4);
    check(max_ph < 32.0, "R7_max_gap", int'(max_ph), 30);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule